// File: doc/BRIEF.md
# GF(2^8) P/Q Parity Datapath

This block computes redundancy for a disk array from word streams. Each operation has a fixed number of sources. For each block position, one 32-bit beat per source arrives in source order. Every beat is split into four byte lanes, and all four lanes use the same coefficient. Across the sources, the block accumulates a plain XOR parity (P). In the same pass it accumulates a syndrome (Q), which is the XOR of each byte multiplied in GF(2^8) by that source's coefficient. After the last source of a position, both results appear together for one cycle, and the accumulators restart for the next position.

A start pulse latches the whole job setup: the source count, the per-source coefficient array, the mode flags and the low byte of the reduction polynomial. The polynomial is x^8 plus that byte. In continuation mode, the fetch side streams earlier partial results as extra sources after the data sources, and the block supplies fixed coefficients for them. A lone data source is treated as that source repeated with coefficient zero.

Top module: `pq_parity_engine`

## Requirements
- R1: After reset, `outValid`, `pOut` and `qOut` are all zero.
- R2: `qOut` byte lane k is the GF(2^8) sum, taken over the consumed beats, of coefficient times byte k of the beat. The multiply reduces by x^8 + `polyCfg`. All four lanes use the beat's coefficient. Data source i takes `coefIn[8i+7:8i]`.
- R3: `pOut` is the XOR of every consumed beat, so every P coefficient is one.
- R4: `srcCntM1` holds the data source count minus one (1 to 16 sources). A beat is consumed on a cycle with `inValid` high. After the last source of a position, `outValid` is high for exactly the next cycle with that position's results. The next beat then begins a new position.
- R5: With a single data source, each position consumes one beat. The block acts as if that beat were repeated with coefficient zero, so `qOut` = c0·d and `pOut` = 0.
- R6: With `contMode`=1 and `dualMode`=0, one extra beat follows the data sources. It carries the previous destination and has Q coefficient 1.
- R7: With `contMode`=1 and `dualMode`=1, three extra beats follow the data sources. They carry old P, then old Q, then old Q again. Their Q coefficients are 0, 0 and 1, and their P coefficient is 1.
- R8: Configuration, including `polyCfg` and `coefIn`, is sampled only on `start`. Changing it during a job has no effect on results.
- R9: Beats are ignored before the first `start` after reset, and on any cycle with `start` high. `start` restarts the source index at zero.
- R10: Cycles with `inValid` low leave the accumulators and the source position unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Latch job setup and restart the source index |
| srcCntM1 | input | 4 | Data source count minus one |
| dualMode | input | 1 | Dual-output continuation layout (three extras) |
| contMode | input | 1 | Continuation: extra beats follow the data sources |
| polyCfg | input | 8 | Low byte of the reduction polynomial |
| coefIn | input | 128 | Per-source Q coefficients, source i in bits 8i+7:8i |
| inValid | input | 1 | A source beat is present |
| inData | input | 32 | Source beat, four byte lanes |
| outValid | output | 1 | Results valid for one cycle |
| pOut | output | 32 | Plain XOR parity |
| qOut | output | 32 | Coefficient-weighted GF(2^8) syndrome |

## Verification
The first pattern is a lone source with a textbook product (0x57·0x83 = 0xC1 under 0x1B). It separates a correct multiplier and the zero-weight repeat from an XOR-only datapath. Full sixteen-source jobs with random coefficients and irregular gaps show whether source indexing, coefficient selection and stall handling agree with a behavioural model over several positions. Single and dual continuation jobs test whether the fixed extra coefficients are applied, since old Q must cancel in P but count once in Q. A second polynomial, with `polyCfg`/`coefIn` disturbed mid-job and beats offered before and during `start`, tests whether the setup is held from the start pulse and stray beats are dropped.

// File: rtl/pq_parity_pkg.sv
package pq_parity_pkg;
  localparam int GF_W = 8;

  // Per-beat strobes from the sequencer to the lane datapath
  typedef struct packed {
    logic            take;       // beat consumed this cycle
    logic            firstBeat;  // source index zero
    logic            lastBeat;   // final source of the position
    logic            pKeep;      // beat contributes to P
    logic [GF_W-1:0] qCoef;      // Q weight of this beat
    logic [GF_W-1:0] poly;       // latched reduction byte
  } pqStrobe_t;
endpackage

// File: rtl/pq_gf_mul.sv
module pq_gf_mul #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] poly,
  output logic [W-1:0] prod
);
  logic [W-1:0] shiftA;
  logic [W-1:0] accum;

  // shift-and-add, reducing the running multiplicand each step
  always_comb begin
    accum  = '0;
    shiftA = a;
    for (int i = 0; i < W; i++) begin
      if (b[i]) accum = accum ^ shiftA;
      shiftA = shiftA[W-1] ? ({shiftA[W-2:0], 1'b0} ^ poly) : {shiftA[W-2:0], 1'b0};
    end
    prod = accum;
  end
endmodule

// File: rtl/pq_seq_ctrl.sv
module pq_seq_ctrl
  import pq_parity_pkg::*;
#(
  parameter int MAX_SRC = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     start,
  input  logic [$clog2(MAX_SRC)-1:0] srcCntM1,
  input  logic                     dualMode,
  input  logic                     contMode,
  input  logic [GF_W-1:0]          polyCfg,
  input  logic [MAX_SRC*GF_W-1:0]  coefIn,
  input  logic                     inValid,
  output pqStrobe_t                stb
);
  localparam int CNT_W = $clog2(MAX_SRC);
  localparam int IDX_W = $clog2(MAX_SRC + 3);

  logic                    armed;
  logic [CNT_W-1:0]        cntM1Q;
  logic                    dualQ;
  logic                    contQ;
  logic [GF_W-1:0]         polyQ;
  logic [MAX_SRC*GF_W-1:0] coefQ;
  logic [IDX_W-1:0]        srcIdx;

  logic [GF_W-1:0] coefArr [MAX_SRC];
  logic [IDX_W-1:0] nData, extraCnt, lastIdx, extraIdx;
  logic [GF_W-1:0] extraCoef;
  logic take;

  for (genvar g = 0; g < MAX_SRC; g++) begin : g_coef
    assign coefArr[g] = coefQ[g*GF_W +: GF_W];
  end

  always_comb begin
    nData     = IDX_W'(cntM1Q) + IDX_W'(1);
    extraCnt  = contQ ? (dualQ ? IDX_W'(3) : IDX_W'(1)) : '0;
    lastIdx   = nData + extraCnt - IDX_W'(1);
    extraIdx  = srcIdx - nData;
    extraCoef = dualQ ? ((extraIdx == IDX_W'(2)) ? GF_W'(1) : '0) : GF_W'(1);
    take      = armed && inValid && !start;

    stb.take      = take;
    stb.firstBeat = (srcIdx == '0);
    stb.lastBeat  = (srcIdx == lastIdx);
    stb.pKeep     = !((cntM1Q == '0) && (srcIdx == '0));
    stb.qCoef     = (srcIdx < nData) ? coefArr[srcIdx[CNT_W-1:0]] : extraCoef;
    stb.poly      = polyQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed  <= 1'b0;
      cntM1Q <= '0;
      dualQ  <= 1'b0;
      contQ  <= 1'b0;
      polyQ  <= '0;
      coefQ  <= '0;
      srcIdx <= '0;
    end else if (start) begin
      armed  <= 1'b1;
      cntM1Q <= srcCntM1;
      dualQ  <= dualMode;
      contQ  <= contMode;
      polyQ  <= polyCfg;
      coefQ  <= coefIn;
      srcIdx <= '0;
    end else if (take) begin
      srcIdx <= (srcIdx == lastIdx) ? '0 : srcIdx + IDX_W'(1);
    end
  end

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> srcIdx <= lastIdx); // R4

  AST_STALL_HOLDS_IDX: assert property (@(posedge clk) disable iff (!rstN)
    (!inValid && !start) |=> $stable(srcIdx)); // R10
endmodule

// File: rtl/pq_lane_datapath.sv
module pq_lane_datapath
  import pq_parity_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  pqStrobe_t              stb,
  input  logic [LANES*GF_W-1:0]  inData,
  output logic                   outValid,
  output logic [LANES*GF_W-1:0]  pOut,
  output logic [LANES*GF_W-1:0]  qOut
);
  localparam int DW = LANES * GF_W;

  logic [DW-1:0] accP, accQ, prodAll, nextP, nextQ;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    pq_gf_mul #(.W(GF_W)) u_mul (
      .a    (inData[l*GF_W +: GF_W]),
      .b    (stb.qCoef),
      .poly (stb.poly),
      .prod (prodAll[l*GF_W +: GF_W])
    );
  end

  always_comb begin
    nextP = (stb.firstBeat ? '0 : accP) ^ (stb.pKeep ? inData : '0);
    nextQ = (stb.firstBeat ? '0 : accQ) ^ prodAll;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accP     <= '0;
      accQ     <= '0;
      outValid <= 1'b0;
      pOut     <= '0;
      qOut     <= '0;
    end else begin
      outValid <= stb.take && stb.lastBeat;
      if (stb.take) begin
        accP <= nextP;
        accQ <= nextQ;
        if (stb.lastBeat) begin
          pOut <= nextP;
          qOut <= nextQ;
        end
      end
    end
  end

  AST_LONE_SRC_P_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (stb.take && stb.firstBeat && stb.lastBeat && !stb.pKeep) |=> pOut == '0); // R5

  AST_ZERO_WEIGHT_LONE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.take && stb.firstBeat && stb.lastBeat && stb.qCoef == '0) |=> qOut == '0); // R2
endmodule

// File: rtl/pq_parity_engine.sv
module pq_parity_engine
  import pq_parity_pkg::*;
#(
  parameter int MAX_SRC = 16,
  parameter int LANES   = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          start,
  input  logic [$clog2(MAX_SRC)-1:0]    srcCntM1,
  input  logic                          dualMode,
  input  logic                          contMode,
  input  logic [7:0]                    polyCfg,
  input  logic [MAX_SRC*8-1:0]          coefIn,
  input  logic                          inValid,
  input  logic [LANES*8-1:0]            inData,
  output logic                          outValid,
  output logic [LANES*8-1:0]            pOut,
  output logic [LANES*8-1:0]            qOut
);
  pqStrobe_t stb;

  pq_seq_ctrl #(.MAX_SRC(MAX_SRC)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .srcCntM1 (srcCntM1),
    .dualMode (dualMode),
    .contMode (contMode),
    .polyCfg  (polyCfg),
    .coefIn   (coefIn),
    .inValid  (inValid),
    .stb      (stb)
  );

  pq_lane_datapath #(.LANES(LANES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .inData   (inData),
    .outValid (outValid),
    .pOut     (pOut),
    .qOut     (qOut)
  );

  AST_OUT_NEEDS_BEAT: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid && !start)); // R4

  AST_START_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    start |=> !outValid); // R9
endmodule

// File: tb/pq_parity_engine_test.sv
`timescale 1ns/1ps
module pq_parity_engine_test;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [3:0]   srcCntM1 = '0;
  logic         dualMode = 1'b0;
  logic         contMode = 1'b0;
  logic [7:0]   polyCfg = '0;
  logic [127:0] coefIn = '0;
  logic         inValid = 1'b0;
  logic [31:0]  inData = '0;
  logic         outValid;
  logic [31:0]  pOut, qOut;

  int    vectors = 0;
  int    miscompares = 0;
  string curReq = "R1";
  bit    cmpOn = 1'b0;

  always #2.5 clk = ~clk;

  pq_parity_engine uut (
    .clk(clk), .rstN(rstN), .start(start), .srcCntM1(srcCntM1),
    .dualMode(dualMode), .contMode(contMode), .polyCfg(polyCfg),
    .coefIn(coefIn), .inValid(inValid), .inData(inData),
    .outValid(outValid), .pOut(pOut), .qOut(qOut)
  );

  // MSB-first Horner multiply, independent of the design's loop order
  function automatic logic [7:0] gfRef(input logic [7:0] c, input logic [7:0] d,
                                       input logic [7:0] poly);
    logic [7:0] r;
    r = '0;
    for (int i = 7; i >= 0; i--) begin
      r = r[7] ? ({r[6:0], 1'b0} ^ poly) : {r[6:0], 1'b0};
      if (c[i]) r = r ^ d;
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [7:0]  coefList[$];
  bit          keepList[$];
  bit          mArmed = 0;
  int          mIdx = 0;
  logic [7:0]  mPoly = '0;
  logic [31:0] mAccP = '0, mAccQ = '0;
  logic        expValid = 0;
  logic [31:0] expP = '0, expQ = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      mArmed = 0; mIdx = 0; expValid = 0; expP = '0; expQ = '0;
      coefList.delete(); keepList.delete();
    end else begin
      expValid = 0;
      if (start) begin
        int nd;
        coefList.delete(); keepList.delete();
        nd = int'(srcCntM1) + 1;
        for (int i = 0; i < nd; i++) begin
          coefList.push_back(coefIn[i*8 +: 8]);
          keepList.push_back(nd != 1);
        end
        if (contMode) begin
          if (dualMode) begin
            coefList.push_back(8'd0); keepList.push_back(1);
            coefList.push_back(8'd0); keepList.push_back(1);
            coefList.push_back(8'd1); keepList.push_back(1);
          end else begin
            coefList.push_back(8'd1); keepList.push_back(1);
          end
        end
        mPoly = polyCfg; mArmed = 1; mIdx = 0;
      end else if (mArmed && inValid) begin
        logic [31:0] pT, qT;
        for (int l = 0; l < 4; l++) begin
          pT[l*8 +: 8] = keepList[mIdx] ? inData[l*8 +: 8] : 8'h00;
          qT[l*8 +: 8] = gfRef(coefList[mIdx], inData[l*8 +: 8], mPoly);
        end
        if (mIdx == 0) begin mAccP = pT; mAccQ = qT; end
        else begin mAccP ^= pT; mAccQ ^= qT; end
        if (mIdx == coefList.size() - 1) begin
          expValid = 1; expP = mAccP; expQ = mAccQ; mIdx = 0;
        end else mIdx++;
      end
    end
  end

  always @(negedge clk) begin
    if (cmpOn) begin
      chk({curReq, " outValid"}, {31'd0, outValid}, {31'd0, expValid});
      chk({curReq, " pOut"}, pOut, expP);
      chk({curReq, " qOut"}, qOut, expQ);
    end
  end

  // ---------------- stimulus ----------------
  task automatic startJob(input logic [3:0] cnt, input bit dual, input bit cont,
                          input logic [7:0] poly, input logic [127:0] coefs, input bit withBeat);
    srcCntM1 = cnt; dualMode = dual; contMode = cont; polyCfg = poly; coefIn = coefs;
    start = 1'b1;
    inValid = withBeat; inData = 32'hDEADBEEF;
    @(negedge clk);
    start = 1'b0; inValid = 1'b0; inData = '0;
  endtask

  task automatic beat(input logic [31:0] d, input int gap);
    repeat (gap) @(negedge clk);
    inValid = 1'b1; inData = d;
    @(negedge clk);
    inValid = 1'b0; inData = '0;
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    miscompares++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [127:0] cf;
    logic [31:0]  xorAll, qAll, d, oldP, oldQ;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk("R1 outValid", {31'd0, outValid}, 32'd0);
    chk("R1 pOut", pOut, 32'd0);
    chk("R1 qOut", qOut, 32'd0);
    @(negedge clk);
    cmpOn = 1'b1;

    // R9: beats before any start are dropped
    curReq = "R9 pre-start";
    beat(32'hA5A5A5A5, 0);
    beat(32'h12345678, 0);
    chk("R9 no output before start", {31'd0, outValid}, 32'd0);

    // R5 / R2: lone source, known product 0x57*0x83 = 0xC1 mod 0x11B
    curReq = "R5 lone source";
    startJob(4'd0, 0, 0, 8'h1B, 128'h83, 0);
    beat(32'h57575757, 0);
    chk("R2 known product", qOut, 32'hC1C1C1C1);
    chk("R5 lone P zero", pOut, 32'h0);
    chk("R4 result flagged", {31'd0, outValid}, 32'd1);
    beat(32'h01802A57, 0);
    beat(32'hFF00FF00, 1);

    // R2 / R3 / R4 / R10: sixteen sources, random weights, gaps
    curReq = "R2 R3 R4 R10 sixteen sources";
    for (int i = 0; i < 16; i++) cf[i*8 +: 8] = 8'($urandom);
    startJob(4'd15, 0, 0, 8'h1B, cf, 0);
    for (int pos = 0; pos < 3; pos++) begin
      xorAll = '0; qAll = '0;
      for (int s = 0; s < 16; s++) begin
        d = $urandom;
        xorAll ^= d;
        for (int l = 0; l < 4; l++) qAll[l*8 +: 8] ^= gfRef(cf[s*8 +: 8], d[l*8 +: 8], 8'h1B);
        beat(d, (s % 3 == 0) ? int'($urandom % 3) : 0);
      end
      chk("R3 parity of sixteen", pOut, xorAll);
      chk("R2 syndrome of sixteen", qOut, qAll);
      chk("R10 gaps keep position", {31'd0, outValid}, 32'd1);
    end

    // R6: single-output continuation, back-to-back beats
    curReq = "R6 single continuation";
    cf = '0; cf[7:0] = 8'h02; cf[15:8] = 8'h1D; cf[23:16] = 8'hF3;
    startJob(4'd2, 0, 1, 8'h1B, cf, 0);
    for (int pos = 0; pos < 2; pos++) begin
      qAll = '0;
      for (int s = 0; s < 4; s++) begin
        d = $urandom;
        for (int l = 0; l < 4; l++)
          qAll[l*8 +: 8] ^= (s == 3) ? d[l*8 +: 8] : gfRef(cf[s*8 +: 8], d[l*8 +: 8], 8'h1B);
        beat(d, 0);
      end
      chk("R6 extra source weight one", qOut, qAll);
    end

    // R7: dual continuation, old P / old Q / old Q
    curReq = "R7 dual continuation";
    cf = '0; cf[31:0] = 32'h09_35_C4_07;
    startJob(4'd3, 1, 1, 8'h1B, cf, 0);
    for (int pos = 0; pos < 2; pos++) begin
      xorAll = '0; qAll = '0;
      for (int s = 0; s < 4; s++) begin
        d = $urandom; xorAll ^= d;
        for (int l = 0; l < 4; l++) qAll[l*8 +: 8] ^= gfRef(cf[s*8 +: 8], d[l*8 +: 8], 8'h1B);
        beat(d, 0);
      end
      oldP = $urandom; oldQ = $urandom;
      beat(oldP, 0); beat(oldQ, 1); beat(oldQ, 0);
      chk("R7 P keeps old P only", pOut, xorAll ^ oldP);
      chk("R7 Q adds old Q once", qOut, qAll ^ oldQ);
    end

    // R8: second polynomial, setup disturbed mid-job
    curReq = "R8 latched setup";
    cf = '0; cf[15:0] = 16'h8E_53;
    startJob(4'd1, 0, 0, 8'h1D, cf, 0);
    for (int pos = 0; pos < 2; pos++) begin
      qAll = '0;
      for (int s = 0; s < 2; s++) begin
        d = $urandom;
        for (int l = 0; l < 4; l++) qAll[l*8 +: 8] ^= gfRef(cf[s*8 +: 8], d[l*8 +: 8], 8'h1D);
        polyCfg = 8'h1B; coefIn = '1;
        beat(d, 0);
      end
      chk("R8 polynomial from start", qOut, qAll);
    end

    // R9: beat presented with start is dropped, index restarts
    curReq = "R9 start with beat";
    startJob(4'd1, 0, 0, 8'h1B, 128'h0301, 1);
    chk("R9 no output at start", {31'd0, outValid}, 32'd0);
    beat(32'h11223344, 0);
    chk("R9 first beat not last", {31'd0, outValid}, 32'd0);
    beat(32'h55667788, 0);
    chk("R9 two beats after start", pOut, 32'h11223344 ^ 32'h55667788);
    repeat (3) @(negedge clk);

    report();
  end
endmodule